// File: doc/BRIEF.md
# Mailbox Request Packer and Handshake Controller

This controller sits on the requesting side of a 256-bit shared mailbox. The mailbox is organised as eight 32-bit words, and word 7 is the control (header) word. On a start command the controller sends one of two messages. A setup message carries four page-aligned queue addresses and a 16-bit interrupt vector. A teardown message carries only a header. Bit 31 of the header word tells which side owns the mailbox. The controller waits until it owns the mailbox, writes the message, and writing the header word last hands the mailbox to the responder. It then waits for the mailbox to come back and checks the response header.

Each wait is a poll loop. A poll is one read of word 7, and polls are separated by a fixed number of idle cycles. After a fixed number of polls that all show the mailbox owned by the responder, the controller gives up. Every mailbox access is a single-word read or write, issued only in a cycle where the bus is granted. When the operation ends, the controller pulses `done` and presents a 2-bit result code: 0 ok, 1 invalid argument, 2 timeout, 3 protocol error.

Top module: `mbox_req_ctrl`

## Requirements
- R1: After reset, `done`=0, `result`=0, `timeout`=0, and `bus_req`, `mb_rd` and `mb_wr` are all low.
- R2: A setup request is rejected with result 1 if any of the four addresses has a nonzero bit below `PAGE_SHIFT`, or if `vector[31:16]` is nonzero. A rejected request makes no mailbox read or write. A teardown request skips both of these checks.
- R3: Before writing, the controller reads word 7 until bit 31 reads 0. Consecutive polls are at least `POLL_GAP` idle cycles apart. After `POLL_MAX` polls that all read bit 31 as 1, it ends with result 2 and `timeout`=1, and it has written nothing.
- R4: A setup writes words 0 to 7 in ascending order. The frame number is the address shifted right by `PAGE_SHIFT` (52 bits). In the little-endian 256-bit image:
  - bits 0..191 hold the low 48 bits of the frame numbers, in the order event, completion, receive, send;
  - bits 192..207 hold their high nibbles, with the event queue's nibble in bits 195:192;
  - bits 208..223 hold the vector;
  - bits 224..255 hold the header word.
- R5: The request header word has type 1 (setup) or 2 (teardown) in bits 2:0 and the reset flag in bit 24. All other bits are 0: version (bits 5:3) is 0, direction (bit 7) is 0 and status (bits 15:8) is 0.
- R6: A teardown writes only word 7.
- R7: After the final write, the controller polls word 7 again in the same way as in R3. When bit 31 reads 0, the response is judged. It is ok (result 0) only if its type matches the request, its version is not above 0, its direction bit 7 is 1 and its status is 0. Otherwise the result is 3.
- R8: If the reset flag was set, an all-ones read while waiting for the response ends the operation with result 0. Without the flag, an all-ones read counts as owned by the responder, and polling continues until timeout.
- R9: `mb_rd` and `mb_wr` are asserted only in cycles with `bus_gnt` high, never both in one cycle. `bus_req` is high while an access is pending.
- R10: `done` is a one-cycle pulse. `result` and `timeout` change only together with `done` and then hold. A start command given while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| teardown | input | 1 | 1 selects the teardown message, 0 the setup message |
| reset_flag | input | 1 | Reset-request flag carried in header bit 24 |
| eq_addr | input | 52+PAGE_SHIFT | Event queue address |
| cq_addr | input | 52+PAGE_SHIFT | Completion queue address |
| rq_addr | input | 52+PAGE_SHIFT | Receive queue address |
| sq_addr | input | 52+PAGE_SHIFT | Send queue address |
| vector | input | 32 | Interrupt vector, must fit in 16 bits |
| bus_req | output | 1 | Mailbox access pending |
| bus_gnt | input | 1 | Access permitted this cycle |
| mb_wr | output | 1 | Word write strobe |
| mb_rd | output | 1 | Word read strobe |
| mb_addr | output | 3 | Word index |
| mb_wdata | output | 32 | Write data |
| mb_rdata | input | 32 | Read data, qualified by mb_rvalid |
| mb_rvalid | input | 1 | Read data valid |
| done | output | 1 | Operation finished (one-cycle pulse) |
| result | output | 2 | 0 ok, 1 invalid, 2 timeout, 3 protocol error |
| timeout | output | 1 | Last operation ended by timeout |

## Verification
The bench uses directed tests, and each test is built so that two functions meet in the same cycle.

- **Start while busy.** A new start pulse is applied while the setup write burst is in flight. The test is judged by the write log: there must be exactly eight writes in ascending order, and exactly one `done` pulse.
- **Withheld grant.** The bus grant is toggled so that grant-free cycles fall in the middle of the write burst and on poll reads. The packed words must come out unchanged.
- **Reset flag against ownership.** In the response poll, the reset flag is set and the read is all-ones, so the all-ones rule meets the ownership bit. This run is compared with the same response seen without the flag, which must time out instead.

// File: rtl/mbox_req_ctrl.sv
module mbox_req_ctrl #(
  parameter int PAGE_SHIFT = 12,
  parameter int POLL_MAX   = 20000,
  parameter int POLL_GAP   = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     teardown,
  input  logic                     reset_flag,
  input  logic [52+PAGE_SHIFT-1:0] eq_addr,
  input  logic [52+PAGE_SHIFT-1:0] cq_addr,
  input  logic [52+PAGE_SHIFT-1:0] rq_addr,
  input  logic [52+PAGE_SHIFT-1:0] sq_addr,
  input  logic [31:0]              vector,
  output logic                     bus_req,
  input  logic                     bus_gnt,
  output logic                     mb_wr,
  output logic                     mb_rd,
  output logic [2:0]               mb_addr,
  output logic [31:0]              mb_wdata,
  input  logic [31:0]              mb_rdata,
  input  logic                     mb_rvalid,
  output logic                     done,
  output logic [1:0]               result,
  output logic                     timeout
);
  localparam int AW  = 52 + PAGE_SHIFT;
  localparam int PCW = $clog2(POLL_MAX + 1);
  localparam int GCW = $clog2(POLL_GAP + 1);
  localparam logic [1:0] RES_OK = 2'd0, RES_INVAL = 2'd1, RES_TMO = 2'd2, RES_PROTO = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RWAIT, S_GAP, S_WR} st_t;

  st_t            st;
  logic           post;
  logic [255:0]   msg;
  logic [2:0]     widx;
  logic [PCW-1:0] polls;
  logic [GCW-1:0] gap;

  wire [51:0] fe = eq_addr[AW-1:PAGE_SHIFT];
  wire [51:0] fc = cq_addr[AW-1:PAGE_SHIFT];
  wire [51:0] fr = rq_addr[AW-1:PAGE_SHIFT];
  wire [51:0] fs = sq_addr[AW-1:PAGE_SHIFT];

  wire [31:0]  req_hdr    = {7'd0, reset_flag, 21'd0, teardown ? 3'd2 : 3'd1};
  wire [255:0] packed_msg = {req_hdr, vector[15:0],
                             fs[51:48], fr[51:48], fc[51:48], fe[51:48],
                             fs[47:0], fr[47:0], fc[47:0], fe[47:0]};

  wire misalign = |{eq_addr[PAGE_SHIFT-1:0], cq_addr[PAGE_SHIFT-1:0],
                    rq_addr[PAGE_SHIFT-1:0], sq_addr[PAGE_SHIFT-1:0]};
  wire bad_args = !teardown && (misalign || |vector[31:16]);

  wire rsp_all1  = &mb_rdata;
  wire owned     = mb_rdata[31];
  wire rsp_good  = (mb_rdata[2:0] == msg[226:224]) && (mb_rdata[5:3] <= msg[229:227]) &&
                   mb_rdata[7] && (mb_rdata[15:8] == 8'd0);
  wire last_poll = polls == PCW'(POLL_MAX - 1);
  wire unused_rd = ^{mb_rdata[30:16], mb_rdata[6]};

  assign bus_req  = (st == S_RD) || (st == S_WR);
  assign mb_rd    = (st == S_RD) && bus_gnt;
  assign mb_wr    = (st == S_WR) && bus_gnt;
  assign mb_addr  = (st == S_WR) ? widx : 3'd7;
  assign mb_wdata = msg[{widx, 5'b0} +: 32];
  assign timeout  = result == RES_TMO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      post   <= 1'b0;
      msg    <= '0;
      widx   <= 3'd0;
      polls  <= '0;
      gap    <= '0;
      done   <= 1'b0;
      result <= RES_OK;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (bad_args) begin
            result <= RES_INVAL;
            done   <= 1'b1;
          end else begin
            msg   <= packed_msg;
            widx  <= teardown ? 3'd7 : 3'd0;
            post  <= 1'b0;
            polls <= '0;
            st    <= S_RD;
          end
        end
        S_RD: if (bus_gnt) st <= S_RWAIT;
        S_RWAIT: if (mb_rvalid) begin
          if (post && msg[248] && rsp_all1) begin
            result <= RES_OK;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else if (!owned) begin
            if (!post) st <= S_WR;
            else begin
              result <= rsp_good ? RES_OK : RES_PROTO;
              done   <= 1'b1;
              st     <= S_IDLE;
            end
          end else if (last_poll) begin
            result <= RES_TMO;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else begin
            polls <= polls + PCW'(1);
            gap   <= '0;
            st    <= S_GAP;
          end
        end
        S_GAP: if (gap >= GCW'(POLL_GAP - 1)) st <= S_RD;
               else gap <= gap + GCW'(1);
        S_WR: if (bus_gnt) begin
          if (widx == 3'd7) begin
            post  <= 1'b1;
            polls <= '0;
            st    <= S_RD;
          end else widx <= widx + 3'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbox_req_ctrl_chk.sv
module mbox_req_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_gnt,
  input logic        mb_wr,
  input logic        mb_rd,
  input logic [2:0]  mb_addr,
  input logic        done,
  input logic [1:0]  result,
  input logic        timeout
);
  // R9
  gnt_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr || mb_rd) |-> (bus_gnt && bus_req));
  // R9
  single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_wr && mb_rd));
  // R3
  poll_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rd |-> mb_addr == 3'd7);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  // R6
  handoff_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr && mb_addr == 3'd7) |=> !mb_wr);
  // R3
  timeout_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);
endmodule

bind mbox_req_ctrl mbox_req_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mb_wr(mb_wr), .mb_rd(mb_rd), .mb_addr(mb_addr), .done(done),
  .result(result), .timeout(timeout)
);

// File: tb/mbox_req_ctrl_test.sv
`timescale 1ns/1ps
module mbox_req_ctrl_test;
  localparam int PS = 12;
  localparam int PMAX = 6;
  localparam int PGAP = 3;
  localparam int AW = 52 + PS;

  logic clk = 0, rst_n = 0;
  logic start = 0, teardown = 0, reset_flag = 0;
  logic [AW-1:0] eq_addr = '0, cq_addr = '0, rq_addr = '0, sq_addr = '0;
  logic [31:0] vector = '0;
  logic bus_req, bus_gnt, mb_wr, mb_rd, mb_rvalid;
  logic [2:0] mb_addr;
  logic [31:0] mb_wdata, mb_rdata;
  logic done, timeout;
  logic [1:0] result;

  always #4 clk = ~clk;

  mbox_req_ctrl #(.PAGE_SHIFT(PS), .POLL_MAX(PMAX), .POLL_GAP(PGAP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .teardown(teardown), .reset_flag(reset_flag),
    .eq_addr(eq_addr), .cq_addr(cq_addr), .rq_addr(rq_addr), .sq_addr(sq_addr),
    .vector(vector), .bus_req(bus_req), .bus_gnt(bus_gnt), .mb_wr(mb_wr), .mb_rd(mb_rd),
    .mb_addr(mb_addr), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata), .mb_rvalid(mb_rvalid),
    .done(done), .result(result), .timeout(timeout));

  logic [31:0] mem [8];
  logic [31:0] wlog [8];
  logic [2:0]  wseq [16];
  int n_wr, n_rd, n_done, cd, cyc;
  logic clr = 0, gnt_mode = 0, gnt_r = 0;
  logic [31:0] init7 = 0, rsp_word = 0;
  int rsp_delay = 2;
  int total = 0, bad = 0;

  assign bus_gnt = gnt_r;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    gnt_r <= gnt_mode ? ~gnt_r : 1'b1;
    mb_rvalid <= mb_rd;
    mb_rdata <= mem[mb_addr];
    if (clr) begin
      for (int k = 0; k < 8; k++) begin mem[k] <= 0; wlog[k] <= 0; end
      mem[7] <= init7;
      cd <= 0; n_wr <= 0; n_rd <= 0; n_done <= 0;
    end else begin
      if (mb_rd) n_rd <= n_rd + 1;
      if (done) n_done <= n_done + 1;
      if (mb_wr) begin
        n_wr <= n_wr + 1;
        if (n_wr < 16) wseq[n_wr] <= mb_addr;
        wlog[mb_addr] <= mb_wdata;
        if (mb_addr == 3'd7) begin
          mem[7] <= mb_wdata | 32'h8000_0000;
          cd <= rsp_delay;
        end else mem[mb_addr] <= mb_wdata;
      end else if (cd > 0) begin
        cd <= cd - 1;
        if (cd == 1) mem[7] <= rsp_word;
      end
    end
  end

  initial cyc = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic prep(input logic [31:0] w7, input logic [31:0] rsp, input int dly);
    @(negedge clk);
    init7 = w7; rsp_word = rsp; rsp_delay = dly; clr = 1;
    @(negedge clk);
    clr = 0;
  endtask

  task automatic go(input logic td, input logic rf, input logic [AW-1:0] e, input logic [AW-1:0] c,
                    input logic [AW-1:0] r, input logic [AW-1:0] s, input logic [31:0] v);
    @(negedge clk);
    teardown = td; reset_flag = rf; eq_addr = e; cq_addr = c; rq_addr = r; sq_addr = s; vector = v;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input int lim, output logic seen);
    seen = 0;
    for (int i = 0; i < lim; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  logic [51:0] F0 = 52'hA_1234_5678_9ABC, F1 = 52'h3_0000_0000_0001,
               F2 = 52'hF_FFFF_FFFF_FFFF, F3 = 52'h5_ABCD_EF01_2345;

  function automatic logic [AW-1:0] adr(input logic [51:0] f);
    return {f, {PS{1'b0}}};
  endfunction

  task automatic exp_words(input logic rf, input logic [15:0] v, output logic [31:0] w [8]);
    logic [7:0] b [32];
    logic [51:0] f [4];
    logic [15:0] h4;
    f[0] = F0; f[1] = F1; f[2] = F2; f[3] = F3;
    h4 = 0;
    for (int q = 0; q < 4; q++) begin
      for (int k = 0; k < 6; k++) b[q*6+k] = f[q][8*k +: 8];
      h4 = h4 | (16'(f[q][51:48]) << (4*q));
    end
    b[24] = h4[7:0]; b[25] = h4[15:8]; b[26] = v[7:0]; b[27] = v[15:8];
    b[28] = 8'h01; b[29] = 8'h00; b[30] = 8'h00; b[31] = {7'd0, rf};
    for (int i = 0; i < 8; i++) w[i] = {b[4*i+3], b[4*i+2], b[4*i+1], b[4*i]};
  endtask

  task automatic t_reset;
    chk("R1 done", done, 0);
    chk("R1 result", result, 0);
    chk("R1 timeout", timeout, 0);
    chk("R1 bus idle", {bus_req, mb_rd, mb_wr}, 0);
  endtask

  task automatic t_setup_ok(input logic gm, input logic rf);
    logic seen; logic [31:0] w [8];
    gnt_mode = gm;
    prep(0, 32'h0000_0081, 3);
    go(0, rf, adr(F0), adr(F1), adr(F2), adr(F3), 32'h0000_BEEF);
    wait_done(400, seen);
    exp_words(rf, 16'hBEEF, w);
    chk("R4 done seen", seen, 1);
    chk("R4 write count", n_wr, 8);
    for (int i = 0; i < 8; i++) begin
      chk("R4 order", wseq[i], i);
      chk(i == 7 ? "R5 header" : "R4 word", wlog[i], w[i]);
    end
    chk("R7 ok result", result, 0);
    chk("R9 grant-gated burst count", n_done, 1);
    gnt_mode = 0;
  endtask

  task automatic t_teardown;
    logic seen;
    prep(0, 32'h0000_0082, 2);
    go(1, 1, 64'h123, 64'h7, 0, 0, 32'hFFFF_0000);
    wait_done(400, seen);
    chk("R6 one write", n_wr, 1);
    chk("R6 word index", wseq[0], 7);
    chk("R5 teardown header", wlog[7], 32'h0100_0002);
    chk("R2 teardown unchecked ok", result, 0);
  endtask

  task automatic t_invalid(input logic [AW-1:0] c, input logic [31:0] v);
    logic seen;
    prep(0, 32'h81, 2);
    go(0, 0, adr(F0), c, adr(F2), adr(F3), v);
    wait_done(4, seen);
    chk("R2 done quickly", seen, 1);
    chk("R2 invalid result", result, 1);
    chk("R2 no access", n_rd + n_wr, 0);
  endtask

  task automatic t_pre_timeout;
    logic seen; int c0, dt;
    prep(32'h8000_0000, 32'h81, 2);
    c0 = cyc;
    go(0, 0, adr(F0), adr(F1), adr(F2), adr(F3), 32'h1);
    wait_done(400, seen);
    dt = cyc - c0;
    chk("R3 timeout result", result, 2);
    chk("R3 timeout flag", timeout, 1);
    chk("R3 poll count", n_rd, PMAX);
    chk("R3 no write", n_wr, 0);
    chk("R3 poll spacing", dt >= PMAX*2 + (PMAX-1)*PGAP, 1);
  endtask

  task automatic t_resp(input logic [31:0] rsp, input logic rf, input logic [1:0] exp, input string tag);
    logic seen;
    prep(0, rsp, 2);
    go(0, rf, adr(F0), adr(F1), adr(F2), adr(F3), 32'h5);
    wait_done(400, seen);
    chk(tag, result, exp);
  endtask

  task automatic t_busy_start;
    logic seen;
    prep(0, 32'h81, 4);
    go(0, 0, adr(F0), adr(F1), adr(F2), adr(F3), 32'h7);
    @(negedge clk); @(negedge clk);
    teardown = 1; start = 1;
    @(negedge clk);
    start = 0;
    wait_done(400, seen);
    repeat (6) @(negedge clk);
    chk("R10 busy start ignored writes", n_wr, 8);
    chk("R10 single done", n_done, 1);
    chk("R10 result held", result, 0);
    chk("R10 bus idle after", bus_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_setup_ok(0, 0);
    t_setup_ok(1, 1);
    t_teardown();
    t_invalid(adr(F1) + 64'h800, 32'h10);
    t_invalid(adr(F1), 32'h0001_0000);
    t_pre_timeout();
    t_resp(32'h0000_0082, 0, 3, "R7 wrong type");
    t_resp(32'h0000_0181, 0, 3, "R7 bad status");
    t_resp(32'h0000_0089, 0, 3, "R7 newer version");
    t_resp(32'h0000_0001, 0, 3, "R7 direction zero");
    t_resp(32'hFFFF_FFFF, 1, 0, "R8 all-ones with flag");
    t_resp(32'hFFFF_FFFF, 0, 2, "R8 all-ones without flag");
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule